// File: doc/BRIEF.md
# Tile Plane-Equation Visibility Resolver

This block resolves hidden surfaces for one square screen tile entirely on chip, with no external depth buffer. Software first clears the tile, then feeds surfaces one at a time. Each surface is a plane given by three depth coefficients and an identifier. For every pixel of the tile the block steps the plane depth incrementally, compares it with the depth already held for that pixel, and keeps the nearer surface's identifier in an on-chip tag store.

A surface can also be marked as a shadow volume. Such a surface never becomes visible. Instead it raises a per-pixel shadow flag wherever it lies in front of the stored depth. When all surfaces have been processed, the tag store is streamed out in raster order. Each output beat carries a surface identifier and a shadow flag, with valid/ready flow control. Each pass covers one pixel per clock.

The tile side is chosen at each clear from two sizes, a small side of 2^SMALL_LOG2 and a large side of twice that. With SMALL_LOG2 set to 5, the two sizes are 32 and 64.

Top module: `tile_vis_resolver`

## Requirements
- R1: After reset, busy, done and out_valid are all 0.
- R2: A clear pass writes identifier 0, shadow flag 0 and the farthest depth (signed maximum, 0x7FFFFFFF) to every pixel. tile_big is sampled only when a clear is accepted: 0 selects a side of 2^SMALL_LOG2 and 1 selects twice that. Later surface passes and readouts keep that side.
- R3: surf_a and surf_b use a 20-bit float format with sign in bit 19, a 6-bit exponent in bits 18:13 (bias 31) and a 13-bit mantissa in bits 12:0 with a hidden leading one. An exponent of 0 means zero. These values are converted to signed 32-bit fixed point with 12 fraction bits, truncating toward zero. surf_c is a signed 20-bit value with 12 fraction bits.
- R4: The depth of pixel (x, y) is C + A·x + B·y, taken modulo 2^32 and compared as a signed 32-bit number. x is the column and y is the row, both starting at 0 at the tile origin.
- R5: An opaque surface replaces the stored identifier and depth only where its depth is strictly smaller. On equal depths the earlier surface stays. A replacement also clears that pixel's shadow flag.
- R6: A shadow surface (surf_is_shadow = 1) leaves identifiers and depths unchanged. It sets the shadow flag at every pixel where its depth is strictly smaller than the stored depth.
- R7: A clear or surface pass on N pixels raises done for exactly one cycle, N+1 cycles after the edge that accepts the start. busy is high from that edge until done, and busy is low while done is high.
- R8: A start of any kind is ignored while busy is high. When starts arrive in the same cycle, clear wins over surface, and surface wins over readout.
- R9: Readout emits pixels in raster order, x fastest, using valid/ready flow control. out_id, out_shadow and out_last hold while out_valid is high and out_ready is low. out_last marks the final pixel. With out_ready held high, one pixel transfers per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_big | input | 1 | Tile size select, sampled at clear accept |
| clr_start | input | 1 | Start a clear pass |
| surf_start | input | 1 | Start a surface pass |
| surf_a | input | 20 | X depth slope, 20-bit float |
| surf_b | input | 20 | Y depth slope, 20-bit float |
| surf_c | input | 20 | Depth at the tile origin, signed fixed point with 12 fraction bits |
| surf_id | input | ID_W | Surface identifier |
| surf_is_shadow | input | 1 | Surface is a shadow volume |
| rd_start | input | 1 | Start readout |
| out_ready | input | 1 | Readout sink ready |
| busy | output | 1 | A pass or readout is in progress |
| done | output | 1 | One-cycle pulse at the end of a clear or surface pass |
| out_valid | output | 1 | Readout beat valid |
| out_id | output | ID_W | Visible surface identifier |
| out_shadow | output | 1 | Shadow flag of the pixel |
| out_last | output | 1 | Final pixel of the tile |

## Verification
Some behaviour is checked by the assertions on every cycle:
- done is a lone pulse that never overlaps busy or readout.
- busy only rises after a start request.
- Readout beats stay frozen under back-pressure.
- out_last never appears without out_valid.

Other behaviour can only be shown by the bench's scenarios, because they require a reference model of the whole tile. These include the resolved identifiers and shadow flags, tie handling, float conversion, shadow clearing on replacement, tile-size latching, and the rejection of starts while busy. The bench checks them by comparing every pixel read out against that model.

// File: rtl/tvr_pkg.sv
package tvr_pkg;
  typedef enum logic [1:0] {
    PASS_CLR = 2'd0,
    PASS_OPQ = 2'd1,
    PASS_SHD = 2'd2
  } pass_kind_t;
endpackage

// File: rtl/tvr_fp_to_fixed.sv
// Converts the compact float slope format into signed fixed point.
module tvr_fp_to_fixed #(
  parameter int EXP_W  = 6,
  parameter int MAN_W  = 13,
  parameter int FRAC_W = 12,
  parameter int OUT_W  = 32
) (
  input  logic [EXP_W+MAN_W:0]     fp,
  output logic signed [OUT_W-1:0]  fx
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int KSH  = BIAS + MAN_W - FRAC_W;
  localparam int WIDE = MAN_W + 1 + (1 << EXP_W) + OUT_W;

  logic [EXP_W-1:0] ex;
  logic [WIDE-1:0]  sig;
  logic [WIDE-1:0]  mag;
  logic [OUT_W-1:0] cut;

  always_comb begin
    ex  = fp[EXP_W+MAN_W-1:MAN_W];
    sig = WIDE'({1'b1, fp[MAN_W-1:0]});
    if (ex == '0)
      mag = '0;
    else if (int'(ex) >= KSH)
      mag = sig << (int'(ex) - KSH);
    else
      mag = sig >> (KSH - int'(ex));
    cut = mag[OUT_W-1:0];
    fx  = fp[EXP_W+MAN_W] ? -$signed(cut) : $signed(cut);
  end
endmodule

// File: rtl/tvr_ram.sv
// Simple dual-port memory with registered read, shaped for block RAM.
module tvr_ram #(
  parameter int W  = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tvr_plane_walker.sv
// Raster pixel counter that steps plane depth incrementally.
module tvr_plane_walker #(
  parameter int LOG2_L = 5,
  parameter int W      = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                step,
  input  logic                big,
  input  logic signed [W-1:0] c0,
  input  logic signed [W-1:0] a_inc,
  input  logic signed [W-1:0] b_inc,
  output logic [LOG2_L-1:0]   x,
  output logic [LOG2_L-1:0]   y,
  output logic signed [W-1:0] depth,
  output logic                last_pix
);
  logic [LOG2_L-1:0] side_last;
  logic signed [W-1:0] row;
  logic signed [W-1:0] row_nx;
  logic last_x;

  assign side_last = big ? '1 : {1'b0, {(LOG2_L-1){1'b1}}};
  assign last_x    = (x == side_last);
  assign last_pix  = last_x && (y == side_last);
  assign row_nx    = row + b_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0; y <= '0; depth <= '0; row <= '0;
    end else if (load) begin
      x <= '0; y <= '0; depth <= c0; row <= c0;
    end else if (step) begin
      if (last_x) begin
        x     <= '0;
        y     <= y + 1'b1;
        row   <= row_nx;
        depth <= row_nx;
      end else begin
        x     <= x + 1'b1;
        depth <= depth + a_inc;
      end
    end
  end
endmodule

// File: rtl/tvr_readout.sv
// Raster readout sequencer; read address looks one pixel ahead on a handshake.
module tvr_readout #(
  parameter int LOG2_L = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  big,
  input  logic                  out_ready,
  output logic                  active,
  output logic [2*LOG2_L-1:0]   raddr,
  output logic                  out_valid,
  output logic                  out_last
);
  logic [LOG2_L-1:0] x, y, nx, ny, side_last;
  logic fetch_q, show_q, last_x, at_end, hs;

  assign side_last = big ? '1 : {1'b0, {(LOG2_L-1){1'b1}}};
  assign last_x    = (x == side_last);
  assign at_end    = last_x && (y == side_last);
  assign hs        = show_q && out_ready;
  assign nx        = last_x ? '0 : x + 1'b1;
  assign ny        = last_x ? y + 1'b1 : y;
  assign raddr     = hs ? {ny, nx} : {y, x};
  assign active    = fetch_q | show_q;
  assign out_valid = show_q;
  assign out_last  = show_q && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q <= 1'b0; show_q <= 1'b0; x <= '0; y <= '0;
    end else if (start) begin
      fetch_q <= 1'b1; x <= '0; y <= '0;
    end else if (fetch_q) begin
      fetch_q <= 1'b0; show_q <= 1'b1;
    end else if (hs) begin
      if (at_end) show_q <= 1'b0;
      else begin
        x <= nx; y <= ny;
      end
    end
  end
endmodule

// File: rtl/tile_vis_resolver.sv
module tile_vis_resolver #(
  parameter int SMALL_LOG2 = 4,
  parameter int ID_W       = 8,
  parameter int EXP_W      = 6,
  parameter int MAN_W      = 13,
  parameter int FRAC_W     = 12,
  parameter int DEPTH_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tile_big,
  input  logic                   clr_start,
  input  logic                   surf_start,
  input  logic [EXP_W+MAN_W:0]   surf_a,
  input  logic [EXP_W+MAN_W:0]   surf_b,
  input  logic [EXP_W+MAN_W:0]   surf_c,
  input  logic [ID_W-1:0]        surf_id,
  input  logic                   surf_is_shadow,
  input  logic                   rd_start,
  input  logic                   out_ready,
  output logic                   busy,
  output logic                   done,
  output logic                   out_valid,
  output logic [ID_W-1:0]        out_id,
  output logic                   out_shadow,
  output logic                   out_last
);
  import tvr_pkg::*;

  localparam int CIN_W  = 1 + EXP_W + MAN_W;
  localparam int LOG2_L = SMALL_LOG2 + 1;
  localparam int AW     = 2 * LOG2_L;
  localparam int MW     = DEPTH_W + ID_W;
  localparam logic signed [DEPTH_W-1:0] FAR = {1'b0, {(DEPTH_W-1){1'b1}}};

  pass_kind_t kind_q;
  logic [ID_W-1:0] id_q;
  logic big_q, walk_q, s1_v, s1_last, done_q;
  logic [AW-1:0] s1_addr, rd_addr, ro_raddr;
  logic signed [DEPTH_W-1:0] a_fx, b_fx, c_fx, a_q, b_q, w_depth, s1_depth, st_depth;
  logic [LOG2_L-1:0] w_x, w_y;
  logic w_last, ro_active, ro_start;
  logic acc_clr, acc_surf;
  logic [MW-1:0] main_wdata, main_rdata;
  logic main_we, sh_we, sh_wdata, sh_rdata, nearer;
  logic [ID_W-1:0] st_id;

  // Start arbitration: clear over surface over readout, nothing while busy.
  assign busy     = walk_q | s1_v | ro_active;
  assign acc_clr  = clr_start & ~busy;
  assign acc_surf = surf_start & ~busy & ~clr_start;
  assign ro_start = rd_start & ~busy & ~clr_start & ~surf_start;

  tvr_fp_to_fixed #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FRAC_W(FRAC_W), .OUT_W(DEPTH_W))
    u_cvt_a (.fp(surf_a), .fx(a_fx));
  tvr_fp_to_fixed #(.EXP_W(EXP_W), .MAN_W(MAN_W), .FRAC_W(FRAC_W), .OUT_W(DEPTH_W))
    u_cvt_b (.fp(surf_b), .fx(b_fx));
  assign c_fx = {{(DEPTH_W-CIN_W){surf_c[CIN_W-1]}}, surf_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      walk_q <= 1'b0; kind_q <= PASS_CLR; id_q <= '0; big_q <= 1'b0;
      a_q <= '0; b_q <= '0;
    end else if (acc_clr) begin
      walk_q <= 1'b1; kind_q <= PASS_CLR; big_q <= tile_big;
      a_q <= '0; b_q <= '0;
    end else if (acc_surf) begin
      walk_q <= 1'b1; kind_q <= surf_is_shadow ? PASS_SHD : PASS_OPQ;
      id_q <= surf_id; a_q <= a_fx; b_q <= b_fx;
    end else if (walk_q && w_last) begin
      walk_q <= 1'b0;
    end
  end

  tvr_plane_walker #(.LOG2_L(LOG2_L), .W(DEPTH_W)) u_walk (
    .clk(clk), .rst(rst), .load(acc_clr | acc_surf), .step(walk_q), .big(big_q),
    .c0(acc_surf ? c_fx : '0), .a_inc(a_q), .b_inc(b_q),
    .x(w_x), .y(w_y), .depth(w_depth), .last_pix(w_last));

  tvr_readout #(.LOG2_L(LOG2_L)) u_ro (
    .clk(clk), .rst(rst), .start(ro_start), .big(big_q), .out_ready(out_ready),
    .active(ro_active), .raddr(ro_raddr), .out_valid(out_valid), .out_last(out_last));

  // Stage 1: stored depth arrives from the registered read; compare and write.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_last <= 1'b0; s1_addr <= '0; s1_depth <= '0; done_q <= 1'b0;
    end else begin
      s1_v     <= walk_q;
      s1_last  <= walk_q & w_last;
      s1_addr  <= {w_y, w_x};
      s1_depth <= w_depth;
      done_q   <= s1_v & s1_last;
    end
  end
  assign done = done_q;

  assign rd_addr  = ro_active ? ro_raddr : {w_y, w_x};
  assign st_depth = main_rdata[MW-1:ID_W];
  assign st_id    = main_rdata[ID_W-1:0];
  assign nearer   = s1_depth < st_depth;

  always_comb begin
    main_we    = 1'b0;
    sh_we      = 1'b0;
    main_wdata = {s1_depth, id_q};
    sh_wdata   = 1'b0;
    if (s1_v) begin
      unique case (kind_q)
        PASS_CLR: begin
          main_we = 1'b1; sh_we = 1'b1; main_wdata = {FAR, {ID_W{1'b0}}};
        end
        PASS_OPQ: begin
          main_we = nearer; sh_we = nearer;
        end
        PASS_SHD: begin
          sh_we = nearer; sh_wdata = 1'b1;
        end
        default: ;
      endcase
    end
  end

  tvr_ram #(.W(MW), .AW(AW)) u_tag (
    .clk(clk), .we(main_we), .waddr(s1_addr), .wdata(main_wdata),
    .raddr(rd_addr), .rdata(main_rdata));
  tvr_ram #(.W(1), .AW(AW)) u_shd (
    .clk(clk), .we(sh_we), .waddr(s1_addr), .wdata(sh_wdata),
    .raddr(rd_addr), .rdata(sh_rdata));

  assign out_id     = st_id;
  assign out_shadow = sh_rdata;
endmodule

// File: rtl/tile_vis_resolver_chk.sv
module tile_vis_resolver_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            clr_start,
  input logic            surf_start,
  input logic            rd_start,
  input logic            out_ready,
  input logic            busy,
  input logic            done,
  input logic            out_valid,
  input logic [ID_W-1:0] out_id,
  input logic            out_shadow,
  input logic            out_last
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !out_valid));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_no_readout_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !done);

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(clr_start || surf_start || rd_start));

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_id) && $stable(out_shadow) && $stable(out_last)));

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_valid_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
endmodule

bind tile_vis_resolver tile_vis_resolver_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .clr_start(clr_start), .surf_start(surf_start),
  .rd_start(rd_start), .out_ready(out_ready), .busy(busy), .done(done),
  .out_valid(out_valid), .out_id(out_id), .out_shadow(out_shadow),
  .out_last(out_last));

// File: tb/tb_tile_vis_resolver.sv
module tb_tile_vis_resolver;
  localparam int SMALL_LOG2 = 4;
  localparam int ID_W = 8;
  localparam int SIDE_S = 1 << SMALL_LOG2;
  localparam int SIDE_L = 2 * SIDE_S;
  localparam int MAXPIX = SIDE_L * SIDE_L;

  // Scene table: {a, b, c, id, shadow}
  localparam int NSCENE = 5;
  localparam logic [68:0] SCENE [NSCENE] = '{
    {20'h00000, 20'h00000, 20'h10000, 8'd1, 1'b0},
    {20'h3E000, 20'h00000, 20'h08000, 8'd2, 1'b0},
    {20'h00000, 20'hBE000, 20'h14000, 8'd3, 1'b0},
    {20'h3D000, 20'hBA000, 20'h0A000, 8'd9, 1'b1},
    {20'hBE000, 20'h3C000, 20'h16000, 8'd4, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tile_big = 1'b0, clr_start = 1'b0, surf_start = 1'b0, rd_start = 1'b0;
  logic [19:0] surf_a = '0, surf_b = '0, surf_c = '0;
  logic [ID_W-1:0] surf_id = '0;
  logic surf_is_shadow = 1'b0, out_ready = 1'b0;
  logic busy, done, out_valid, out_shadow, out_last;
  logic [ID_W-1:0] out_id;

  int checks = 0;
  int errors = 0;

  logic signed [31:0] m_dp [MAXPIX];
  logic [ID_W-1:0]    m_id [MAXPIX];
  logic               m_sh [MAXPIX];

  always #2.5 clk = ~clk;

  tile_vis_resolver #(.SMALL_LOG2(SMALL_LOG2), .ID_W(ID_W)) dut (
    .clk(clk), .rst(rst), .tile_big(tile_big), .clr_start(clr_start),
    .surf_start(surf_start), .surf_a(surf_a), .surf_b(surf_b), .surf_c(surf_c),
    .surf_id(surf_id), .surf_is_shadow(surf_is_shadow), .rd_start(rd_start),
    .out_ready(out_ready), .busy(busy), .done(done), .out_valid(out_valid),
    .out_id(out_id), .out_shadow(out_shadow), .out_last(out_last));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Float slope to fixed point with 12 fraction bits, via real arithmetic.
  function automatic longint slope_fx(input logic [19:0] f);
    int e;
    real r;
    longint mag;
    e = int'(f[18:13]);
    if (e == 0) return 0;
    r = (8192.0 + real'(f[12:0]));
    if (e >= 32) for (int i = 0; i < e - 32; i++) r = r * 2.0;
    else for (int i = 0; i < 32 - e; i++) r = r / 2.0;
    mag = longint'($rtoi(r));
    return f[19] ? -mag : mag;
  endfunction

  task automatic model_clear(input int side);
    for (int i = 0; i < side * side; i++) begin
      m_dp[i] = 32'sh7FFFFFFF; m_id[i] = '0; m_sh[i] = 1'b0;
    end
  endtask

  task automatic model_surf(input logic [68:0] s, input int side);
    longint af, bf, cf, acc;
    logic signed [31:0] d;
    af = slope_fx(s[68:49]);
    bf = slope_fx(s[48:29]);
    cf = longint'($signed(s[28:9]));
    for (int y = 0; y < side; y++)
      for (int x = 0; x < side; x++) begin
        acc = cf + af * x + bf * y;
        d = acc[31:0];
        if (s[0]) begin
          if (d < m_dp[y*side+x]) m_sh[y*side+x] = 1'b1;
        end else if (d < m_dp[y*side+x]) begin
          m_dp[y*side+x] = d; m_id[y*side+x] = s[8:1]; m_sh[y*side+x] = 1'b0;
        end
      end
  endtask

  task automatic wait_done(input int npix, input string tag);
    int cnt;
    cnt = 1;
    while (!done && cnt < 5000) begin
      @(negedge clk); cnt++;
    end
    chk(cnt - 1 == npix + 1, tag, cnt - 1, npix + 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " single pulse"}, done, 0);
  endtask

  task automatic run_clear(input logic big, input int npix);
    @(negedge clk); clr_start = 1'b1; tile_big = big;
    @(negedge clk); clr_start = 1'b0;
    chk(busy == 1'b1, "R7 busy after clear accept", busy, 1);
    wait_done(npix, "R7 clear done latency");
  endtask

  task automatic run_surf(input logic [68:0] s, input int npix);
    @(negedge clk);
    surf_start = 1'b1; surf_a = s[68:49]; surf_b = s[48:29]; surf_c = s[28:9];
    surf_id = s[8:1]; surf_is_shadow = s[0];
    @(negedge clk); surf_start = 1'b0;
    wait_done(npix, "R7 surface done latency");
  endtask

  task automatic run_readout(input int side, input bit throttle);
    int idx, cyc, gaps;
    bit stalled, seen;
    logic [ID_W-1:0] hid;
    logic hsh, hl;
    idx = 0; cyc = 0; gaps = 0; stalled = 0; seen = 0;
    hid = '0; hsh = 1'b0; hl = 1'b0;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    while (idx < side * side && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = throttle ? (cyc % 3 != 0) : 1'b1;
      if (out_valid) begin
        seen = 1;
        if (stalled) begin
          chk(out_id == hid && out_shadow == hsh && out_last == hl,
              "R9 held beat", out_id, hid);
        end
        if (out_ready) begin
          chk(out_id == m_id[idx], $sformatf("R3 R4 R5 id pixel %0d", idx), out_id, m_id[idx]);
          chk(out_shadow == m_sh[idx], $sformatf("R6 shadow pixel %0d", idx), out_shadow, m_sh[idx]);
          chk(out_last == (idx == side * side - 1), $sformatf("R9 last pixel %0d", idx),
              out_last, idx == side * side - 1);
          idx++;
          stalled = 0;
        end else begin
          stalled = 1; hid = out_id; hsh = out_shadow; hl = out_last;
        end
      end else if (seen) begin
        gaps++;
      end
    end
    chk(idx == side * side, "R9 readout count (R2 tile side)", idx, side * side);
    if (!throttle) chk(gaps == 0, "R9 one pixel per cycle", gaps, 0);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && busy == 1'b0, "R9 readout ends", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [68:0] cover7, cover8, big_a, big_b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // R2 clear of the small tile, then read it back
    run_clear(1'b0, SIDE_S * SIDE_S);
    model_clear(SIDE_S);
    run_readout(SIDE_S, 1'b0);

    // Scene table walked by one loop (R3 R4 R5 R6)
    for (int k = 0; k < NSCENE; k++) begin
      run_surf(SCENE[k], SIDE_S * SIDE_S);
      model_surf(SCENE[k], SIDE_S);
    end
    run_readout(SIDE_S, 1'b0);

    // R8: surface and readout requested together -> surface wins;
    // a second surface during the pass is ignored.
    cover7 = {20'h00000, 20'h00000, 20'h9C000, 8'd7, 1'b0};
    cover8 = {20'h00000, 20'h00000, 20'h88000, 8'd8, 1'b0};
    @(negedge clk);
    surf_start = 1'b1; rd_start = 1'b1;
    surf_a = cover7[68:49]; surf_b = cover7[48:29]; surf_c = cover7[28:9];
    surf_id = cover7[8:1]; surf_is_shadow = 1'b0;
    @(negedge clk);
    surf_start = 1'b0; rd_start = 1'b0;
    chk(out_valid == 1'b0, "R8 readout lost to surface", out_valid, 0);
    repeat (10) @(negedge clk);
    surf_start = 1'b1; surf_c = cover8[28:9]; surf_id = cover8[8:1];
    @(negedge clk); surf_start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    model_surf(cover7, SIDE_S);
    run_readout(SIDE_S, 1'b0);

    // R2 large tile, size latched at clear only; throttled readout
    run_clear(1'b1, SIDE_L * SIDE_L);
    model_clear(SIDE_L);
    tile_big = 1'b0;
    big_a = {20'h3E000, 20'h3E000, 20'hD8000, 8'd6, 1'b0};
    big_b = {20'hBE000, 20'h00000, 20'h00000, 8'd11, 1'b0};
    run_surf(big_a, SIDE_L * SIDE_L);
    model_surf(big_a, SIDE_L);
    run_surf(big_b, SIDE_L * SIDE_L);
    model_surf(big_b, SIDE_L);
    run_readout(SIDE_L, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule